// File: doc/BRIEF.md
# DMA Request Sense and Bus Handoff Sequencer

This block is a single DMA channel's sequencer. It watches an active-low request pin and decides, one byte at a time, whether the system bus stays with the DMA engine or goes back to the CPU. Each byte moves in two bus cycles, a read and then a write. Each bus cycle steps through T1, T2, zero or more wait states (TW) and T3.

The request pin can be read in two ways. In level mode its value counts. In edge mode only a falling transition counts, and that transition is held in a latch until the next decision point. The keep-or-release decision is taken once per byte, on the clock edge that ends the write cycle's T2, or that ends its last wait state.

A byte counter is loaded through a small load port. Loading it also arms the channel. The counter counts down once per finished byte, and the transfer-end flag is raised during the byte that is moved while the counter reads zero. When the counter wraps past zero, the channel disarms itself.

Top module: `dreq_handoff`

## Requirements
- R1: After reset, cyc_state is 0 (idle) and bus_req, cyc_write and tend are low. The channel is disarmed, so a request held low does not raise bus_req until a count is loaded.
- R2: Take an armed, idle channel whose request is valid at a clock edge. The next cycle shows cyc_state 1 (arbitration) with bus_req high. The first bus state, read T1 (cyc_state 2, cyc_write 0), follows the edge at which bus_grant is seen high.
- R3: A byte runs as read T1, T2, T3 and then write T1, T2, T3. The state codes are T1=2, T2=3, TW=4 and T3=5. cyc_write is 0 during the read cycle and 1 during the write cycle.
- R4: If wait_req is high at the edge that ends T2 or TW, the next state is TW (4). If it is low, the next state is T3.
- R5: In level mode (edge_mode=0), req_n is sampled at the edge ending write T2 or the last write TW. If it is high, bus_req drops one cycle after write T3. If it is low and the counter has not wrapped, read T1 follows write T3 directly. A low req_n in idle starts a transfer.
- R6: In edge mode (edge_mode=1), a transfer starts only after a falling edge of req_n, meaning req_n was high at one clock edge and low at the next. A request held low with no new edge does not start a transfer.
- R7: In edge mode, if a falling edge was registered after the previous decision and before the sampling edge of the write cycle, the next byte follows at once. If none was, the bus is released after the current byte.
- R8: In edge mode, a falling edge seen on the sampling edge itself does not count for that byte, but it is kept and starts one further transfer after the release.
- R9: The counter decrements at each write T3. tend is high during the read and write cycles of the byte that is moved while the counter holds 0.
- R10: After the byte moved at count 0, the bus is released whatever req_n and the mode are. The channel stays disarmed until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Active-low DMA request |
| edge_mode | input | 1 | 1 = falling-edge request sense, 0 = level sense |
| wait_req | input | 1 | High inserts wait states after T2 |
| cnt_load | input | 1 | Loads the byte counter and arms the channel |
| cnt_value | input | CNT_W | Value loaded into the byte counter |
| bus_grant | input | 1 | Bus granted by the CPU |
| bus_req | output | 1 | Bus requested or held by the DMA channel |
| cyc_state | output | 3 | Sequencer state: 0 idle, 1 arbitration, 2 T1, 3 T2, 4 TW, 5 T3 |
| cyc_write | output | 1 | 1 during the write cycle of a byte |
| tend | output | 1 | High during the final byte transfer |

## Verification
The assertions rely on four things about the environment:
- edge_mode stays stable while a byte is in progress;
- the CPU side keeps bus_grant high for as long as bus_req is high;
- counter loads happen only while the channel is idle;
- wait_req is acted on only in T2 and TW.

The bench satisfies these as follows. It changes mode and issues loads only after the scoreboard has drained and the sequencer is back in idle. Its CPU stub is a single register that echoes bus_req. Wait states are raised only once write T2 has been observed, and they are dropped after a counted number of TW cycles.

// File: rtl/dh_pkg.sv
package dh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARB  = 3'd1,
        ST_T1   = 3'd2,
        ST_T2   = 3'd3,
        ST_TW   = 3'd4,
        ST_T3   = 3'd5
    } dh_state_e;

    typedef struct packed {
        dh_state_e st;
        logic      wr;
        logic      keep;
    } dh_seq_s;

    typedef struct packed {
        logic req_prev;
        logic latch;
    } dh_sense_s;

endpackage

// File: rtl/dh_req_sense.sv
module dh_req_sense
    import dh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic edge_mode,
    input  logic consume,
    output logic want
);

    dh_sense_s s_d, s_q;
    logic      fall_c;

    always_comb begin
        fall_c     = s_q.req_prev & ~req_n;
        s_d.req_prev = req_n;
        // a new edge wins over a clear in the same cycle
        s_d.latch  = fall_c | (s_q.latch & ~consume);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.req_prev <= 1'b1;
            s_q.latch    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign want = edge_mode ? s_q.latch : ~req_n;

endmodule

// File: rtl/dh_byte_count.sv
module dh_byte_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             armed,
    output logic             is_zero
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } cnt_s;

    cnt_s c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.cnt = load_val;
            c_d.en  = 1'b1;
        end else if (dec) begin
            c_d.cnt = c_q.cnt - CNT_ONE;
            if (c_q.cnt == CNT_ZERO) begin
                c_d.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.en  <= 1'b0;
            c_q.cnt <= CNT_ZERO;
        end else begin
            c_q <= c_d;
        end
    end

    assign armed   = c_q.en;
    assign is_zero = (c_q.cnt == CNT_ZERO);

endmodule

// File: rtl/dh_cycle_fsm.sv
module dh_cycle_fsm
    import dh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      armed,
    input  logic      want,
    input  logic      last,
    input  logic      wait_req,
    input  logic      bus_grant,
    output dh_state_e st,
    output logic      wr,
    output logic      consume,
    output logic      dec
);

    dh_seq_s q_d, q_q;

    always_comb begin
        q_d     = q_q;
        consume = 1'b0;
        dec     = 1'b0;
        case (q_q.st)
            ST_IDLE: begin
                if (armed && want) begin
                    q_d.st  = ST_ARB;
                    consume = 1'b1;
                end
            end
            ST_ARB: begin
                if (bus_grant) begin
                    q_d.st = ST_T1;
                    q_d.wr = 1'b0;
                end
            end
            ST_T1: q_d.st = ST_T2;
            ST_T2, ST_TW: begin
                if (wait_req) begin
                    q_d.st = ST_TW;
                end else begin
                    q_d.st = ST_T3;
                    if (q_q.wr) begin
                        consume  = 1'b1;
                        q_d.keep = want;
                    end
                end
            end
            ST_T3: begin
                if (!q_q.wr) begin
                    q_d.st = ST_T1;
                    q_d.wr = 1'b1;
                end else begin
                    dec    = 1'b1;
                    q_d.wr = 1'b0;
                    q_d.st = (!last && q_q.keep) ? ST_T1 : ST_IDLE;
                end
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q.st   <= ST_IDLE;
            q_q.wr   <= 1'b0;
            q_q.keep <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    assign st = q_q.st;
    assign wr = q_q.wr;

endmodule

// File: rtl/dreq_handoff.sv
module dreq_handoff
    import dh_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_n,
    input  logic             edge_mode,
    input  logic             wait_req,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             bus_grant,
    output logic             bus_req,
    output logic [2:0]       cyc_state,
    output logic             cyc_write,
    output logic             tend
);

    dh_state_e st;
    logic      wr, consume, dec, want, armed, is_zero, on_bus;

    dh_req_sense u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (req_n),
        .edge_mode (edge_mode),
        .consume   (consume),
        .want      (want)
    );

    dh_byte_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_value),
        .dec      (dec),
        .armed    (armed),
        .is_zero  (is_zero)
    );

    dh_cycle_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .want      (want),
        .last      (is_zero),
        .wait_req  (wait_req),
        .bus_grant (bus_grant),
        .st        (st),
        .wr        (wr),
        .consume   (consume),
        .dec       (dec)
    );

    assign on_bus    = (st != ST_IDLE) && (st != ST_ARB);
    assign bus_req   = (st != ST_IDLE);
    assign cyc_state = st;
    assign cyc_write = wr;
    assign tend      = armed && is_zero && on_bus;

endmodule

// File: rtl/dh_handoff_chk.sv
module dh_handoff_chk
    import dh_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_n,
    input logic       edge_mode,
    input logic       wait_req,
    input logic       bus_grant,
    input logic       bus_req,
    input logic [2:0] cyc_state,
    input logic       cyc_write,
    input logic       tend
);

    logic in_wait_pt;
    assign in_wait_pt = (cyc_state == ST_T2) || (cyc_state == ST_TW);

    AST_GRANT_TO_T1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_state == ST_ARB && bus_grant) |=> (cyc_state == ST_T1 && !cyc_write)); // R2

    AST_T1_TO_T2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_state == ST_T1) |=> (cyc_state == ST_T2)); // R3

    AST_READ_TO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_state == ST_T3 && !cyc_write) |=> (cyc_state == ST_T1 && cyc_write)); // R3

    AST_WAIT_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait_pt && wait_req) |=> (cyc_state == ST_TW)); // R4

    AST_WAIT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait_pt && !wait_req) |=> (cyc_state == ST_T3)); // R4

    AST_LEVEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && cyc_write && in_wait_pt && !wait_req && req_n) |=> ##1 !bus_req); // R5

    AST_LEVEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && cyc_write && in_wait_pt && !wait_req && !req_n && !tend)
        |=> ##1 (cyc_state == ST_T1 && !cyc_write)); // R5

    AST_WRAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_state == ST_T3 && cyc_write && tend) |=> !bus_req); // R10

endmodule

bind dreq_handoff dh_handoff_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_n     (req_n),
    .edge_mode (edge_mode),
    .wait_req  (wait_req),
    .bus_grant (bus_grant),
    .bus_req   (bus_req),
    .cyc_state (cyc_state),
    .cyc_write (cyc_write),
    .tend      (tend)
);

// File: tb/dreq_handoff_bench.sv
`timescale 1ns/1ps
module dreq_handoff_bench;
    import dh_pkg::*;

    localparam int CNT_W  = 16;
    localparam int EV_BYTE = 0;
    localparam int EV_LAST = 1;
    localparam int EV_REL  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_n = 1'b1;
    logic             edge_mode = 1'b0;
    logic             wait_req = 1'b0;
    logic             cnt_load = 1'b0;
    logic [CNT_W-1:0] cnt_value = '0;
    logic             bus_grant;
    logic             bus_req;
    logic [2:0]       cyc_state;
    logic             cyc_write;
    logic             tend;

    always #2.5 clk = ~clk;

    dreq_handoff #(.CNT_W(CNT_W)) u_dreq_handoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (req_n),
        .edge_mode (edge_mode),
        .wait_req  (wait_req),
        .cnt_load  (cnt_load),
        .cnt_value (cnt_value),
        .bus_grant (bus_grant),
        .bus_req   (bus_req),
        .cyc_state (cyc_state),
        .cyc_write (cyc_write),
        .tend      (tend)
    );

    // CPU stub: grants one cycle after the request and holds while requested
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_grant <= 1'b0;
        else        bus_grant <= bus_req;
    end

    typedef struct {
        int    code;
        string tag;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push_exp(input int code, input string tag);
        exp_t e;
        e.code = code;
        e.tag  = tag;
        expq.push_back(e);
    endtask

    task automatic got(input int code);
        exp_t e;
        if (expq.size() == 0) begin
            check(1'b0, "SCOREBOARD", "unexpected event", code, -1);
        end else begin
            e = expq.pop_front();
            check(code == e.code, e.tag, "event code", code, e.code);
        end
    endtask

    // monitor
    logic prev_req = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cyc_state == 3'(ST_T3) && cyc_write) got(tend ? EV_LAST : EV_BYTE);
            if (prev_req && !bus_req) got(EV_REL);
        end
        prev_req = bus_req;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cycles, 50000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic load(input int val);
        cnt_value = CNT_W'(val);
        cnt_load  = 1'b1;
        tick;
        cnt_load  = 1'b0;
    endtask

    task automatic wait_state(input dh_state_e s, input logic w, input string tag);
        bit found = 1'b0;
        for (int i = 0; i < 300; i++) begin
            tick;
            if (cyc_state == 3'(s) && cyc_write == w) begin
                found = 1'b1;
                break;
            end
        end
        if (!found) check(1'b0, tag, "state never reached", cyc_state, s);
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 2000; i++) begin
            tick;
            if (expq.size() == 0 && cyc_state == 3'(ST_IDLE)) break;
        end
        repeat (4) tick;
        check(expq.size() == 0, tag, "pending expected events", expq.size(), 0);
    endtask

    task automatic quiet(input int n, input string tag);
        int hi = 0;
        for (int i = 0; i < n; i++) begin
            tick;
            if (bus_req) hi++;
        end
        check(hi == 0, tag, "bus_req cycles while idle", hi, 0);
    endtask

    task automatic pulse_edge;
        req_n = 1'b1;
        tick;
        req_n = 1'b0;
    endtask

    initial begin
        int ntw;
        dh_state_e exp_st[5];
        logic      exp_wr[5];

        // R1: reset state
        repeat (4) tick;
        rst_n = 1'b1;
        tick;
        check(cyc_state == 3'd0, "R1", "cyc_state", cyc_state, 0);
        check(bus_req == 1'b0, "R1", "bus_req", bus_req, 0);
        check(cyc_write == 1'b0, "R1", "cyc_write", cyc_write, 0);
        check(tend == 1'b0, "R1", "tend", tend, 0);
        req_n = 1'b0;
        quiet(20, "R1");

        // R2, R3, R9, R10: level mode, count 2, request held low
        push_exp(EV_BYTE, "R9");
        push_exp(EV_BYTE, "R9");
        push_exp(EV_LAST, "R9");
        push_exp(EV_REL, "R10");
        load(2);
        tick;
        check(cyc_state == 3'(ST_ARB) && bus_req, "R2", "arbitration after start",
              cyc_state, ST_ARB);
        tick;
        tick;
        check(cyc_state == 3'(ST_T1) && !cyc_write, "R2", "read T1 after grant",
              cyc_state, ST_T1);
        exp_st = '{ST_T2, ST_T3, ST_T1, ST_T2, ST_T3};
        exp_wr = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
        for (int i = 0; i < 5; i++) begin
            tick;
            check(cyc_state == 3'(exp_st[i]) && cyc_write == exp_wr[i], "R3",
                  "byte state order", {cyc_write, cyc_state}, {exp_wr[i], 3'(exp_st[i])});
        end
        drain("R9");
        quiet(20, "R10");

        // R5: level mode, request goes high before the write sample
        push_exp(EV_BYTE, "R5");
        push_exp(EV_REL, "R5");
        load(5);
        wait_state(ST_T1, 1'b1, "R5");
        req_n = 1'b1;
        drain("R5");
        quiet(10, "R5");

        // R4: wait states move the level sample to the last TW
        push_exp(EV_BYTE, "R4");
        push_exp(EV_LAST, "R5");
        push_exp(EV_REL, "R10");
        load(1);
        req_n = 1'b0;
        wait_state(ST_T2, 1'b1, "R4");
        wait_req = 1'b1;
        req_n    = 1'b1;
        ntw = 0;
        for (int i = 0; i < 10; i++) begin
            tick;
            if (cyc_state == 3'(ST_TW)) begin
                ntw++;
                if (ntw == 3) begin
                    wait_req = 1'b0;
                    req_n    = 1'b0;
                end
            end else begin
                break;
            end
        end
        check(ntw == 3, "R4", "wait states inserted", ntw, 3);
        check(cyc_state == 3'(ST_T3), "R4", "T3 after last wait", cyc_state, ST_T3);
        drain("R4");

        // R6, R7: edge mode
        edge_mode = 1'b1;
        load(5);
        quiet(10, "R6");
        push_exp(EV_BYTE, "R6");
        push_exp(EV_REL, "R7");
        pulse_edge();
        drain("R6");
        quiet(15, "R6");

        push_exp(EV_BYTE, "R7");
        push_exp(EV_BYTE, "R7");
        push_exp(EV_REL, "R7");
        pulse_edge();
        wait_state(ST_T2, 1'b0, "R7");
        pulse_edge();
        drain("R7");

        // R8: edge exactly on the sampling clock is kept for later
        load(5);
        push_exp(EV_BYTE, "R8");
        push_exp(EV_REL, "R8");
        push_exp(EV_BYTE, "R8");
        push_exp(EV_REL, "R8");
        pulse_edge();
        wait_state(ST_T1, 1'b1, "R8");
        req_n = 1'b1;
        tick;
        check(cyc_state == 3'(ST_T2) && cyc_write, "R8", "write T2 reached",
              cyc_state, ST_T2);
        req_n = 1'b0;
        drain("R8");
        quiet(10, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule